// File: doc/BRIEF.md
# Per-Port Shared Input Debounce Bank

This block filters the synchronised pad inputs of one bank of general-purpose pins before they reach the input-sampling and interrupt logic. The bank is split into ports of eight pins each. Every port holds one debounce length, counted in millisecond tick strobes and shared by all of its pins. Every pin has its own filter enable bit. A pin whose enable is clear passes its raw level straight through. An enabled pin presents a new level only after that level has held, unbroken, for the programmed number of ticks.

Software programs the bank over a small word-addressed register bus. The top address bit selects between two register kinds, and the low bits select the port. A length register stores an 8-bit tick count. The enable alias is written in masked form, so single pins can be turned on or off without a read-modify-write. The tick strobe comes from outside the block, and the block does not count clock cycles itself.

Top module: `dbnc_bank`

## Requirements
- R1: While reset is asserted and after it is released, every enable bit and every length register reads 0, and each filtered output equals its raw input.
- R2: A bus write with address bit 2 = 0 and bits 1:0 = port stores wdata[7:0] as that port's length. Bits 15:8 are ignored and other ports are unchanged. A read at the same address returns the length in rdata[7:0], with the upper bits zero.
- R3: A bus write with address bit 2 = 1 and bits 1:0 = port updates only the port's enable bits whose strobe bit wdata[8+i] is 1, setting each to wdata[i]. A read at that address returns the eight enables in rdata[7:0].
- R4: A pin whose enable is 0 drives its raw input to its filtered output in the same cycle.
- R5: For an enabled pin on a port with length N ≥ 1, a level that differs from the filtered output appears on the output right after the clock edge of the N-th tick strobe seen while it differs. Until then the output holds the old level.
- R6: If the raw input returns to the filtered level for at least one clock before N ticks have elapsed, the tick count restarts from zero.
- R7: An enabled pin on a port with length 0 follows its raw input in the same cycle.
- R8: The length of a port governs all eight of its pins, and each port's length is independent of the others.
- R9: Each pin counts its ticks on its own, so pins of one port that change at different ticks settle at different ticks.
- R10: Turning on the enable of a pin whose raw level is steady causes no change at its output.
- R11: Clock cycles without a tick strobe never advance a filter, so the output of an enabled pin with N ≥ 1 changes only at an edge where the tick strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Millisecond strobe, one clock wide |
| pin_raw_i | input | 32 | Synchronised raw pin levels, port p in bits 8p+7:8p |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address: bit 2 selects the enable alias, bits 1:0 select the port |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| pin_filt_o | output | 32 | Filtered pin levels |

## Verification
Register writes take effect at the clock edge of the write cycle and read back combinationally, so the bench reads them on the following negative edge. A bypassed pin, or a pin with length 0, reflects its raw level within the same cycle, and the bench checks it one nanosecond after driving the input. A filtered pin changes at the edge of its N-th qualifying tick. The bench drives each tick for a single cycle and samples at the negative edge after it. Between ticks it inserts idle cycles and checks that nothing has moved, and in the sweeps it compares the whole 32-bit output with a value computed from each port's length and the number of ticks issued.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int unsigned DEF_NUM_PORTS = 4;
  localparam int unsigned DEF_PORT_PINS = 8;
  localparam int unsigned DEF_LIMIT_W   = 8;

  typedef enum logic {
    SEL_LIMIT = 1'b0,
    SEL_EN    = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbnc_pin.sv
module dbnc_pin #(
  parameter int unsigned LIMIT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               raw_i,
  input  logic               en_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               filt_o
);
  logic               filt_q;
  logic [LIMIT_W-1:0] cnt_q;
  logic               limit_zero;
  logic               differ;
  logic               expire;
  logic [LIMIT_W:0]   cnt_next;

  assign limit_zero = (limit_i == '0);
  assign differ     = raw_i ^ filt_q;
  assign cnt_next   = {1'b0, cnt_q} + {{LIMIT_W{1'b0}}, 1'b1};
  assign expire     = (cnt_next >= {1'b0, limit_i});

  // Idle filters shadow the raw level so enabling never glitches.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!en_i || limit_zero || !differ) begin
      filt_q <= raw_i;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (expire) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_next[LIMIT_W-1:0];
      end
    end
  end

  assign filt_o = (en_i && !limit_zero) ? filt_q : raw_i;
endmodule

// File: rtl/dbnc_port.sv
module dbnc_port #(
  parameter int unsigned PORT_PINS = 8,
  parameter int unsigned LIMIT_W   = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [PORT_PINS-1:0] raw_i,
  input  logic [PORT_PINS-1:0] en_i,
  input  logic [LIMIT_W-1:0]   limit_i,
  output logic [PORT_PINS-1:0] filt_o
);
  for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
    dbnc_pin #(
      .LIMIT_W(LIMIT_W)
    ) pin_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .raw_i  (raw_i[i]),
      .en_i   (en_i[i]),
      .limit_i(limit_i),
      .filt_o (filt_o[i])
    );
  end
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs
  import dbnc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_PINS = 8,
  parameter int unsigned LIMIT_W   = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 16
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 bus_wr_i,
  input  logic [ADDR_W-1:0]                    bus_addr_i,
  input  logic [DATA_W-1:0]                    bus_wdata_i,
  output logic [DATA_W-1:0]                    bus_rdata_o,
  output logic [NUM_PORTS-1:0][LIMIT_W-1:0]    limit_o,
  output logic [NUM_PORTS-1:0][PORT_PINS-1:0]  en_o
);
  localparam int unsigned PORT_AW = ADDR_W - 1;

  reg_sel_e               sel;
  logic [PORT_AW-1:0]     idx;
  logic [PORT_PINS-1:0]   strobe;
  logic [PORT_PINS-1:0]   value;

  assign sel    = reg_sel_e'(bus_addr_i[ADDR_W-1]);
  assign idx    = bus_addr_i[PORT_AW-1:0];
  assign strobe = bus_wdata_i[2*PORT_PINS-1:PORT_PINS];
  assign value  = bus_wdata_i[PORT_PINS-1:0];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit = bus_wr_i && (idx == PORT_AW'(p));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        limit_o[p] <= '0;
      end else if (hit && sel == SEL_LIMIT) begin
        limit_o[p] <= bus_wdata_i[LIMIT_W-1:0];
      end
    end

    // Masked alias: only strobed bits take the new value.
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[p] <= '0;
      end else if (hit && sel == SEL_EN) begin
        en_o[p] <= (en_o[p] & ~strobe) | (value & strobe);
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (int'(idx) < int'(NUM_PORTS)) begin
      if (sel == SEL_LIMIT) bus_rdata_o[LIMIT_W-1:0]   = limit_o[idx];
      else                  bus_rdata_o[PORT_PINS-1:0] = en_o[idx];
    end
  end
endmodule

// File: rtl/dbnc_bank.sv
module dbnc_bank
  import dbnc_pkg::*;
#(
  parameter int unsigned NUM_PORTS = DEF_NUM_PORTS,
  parameter int unsigned PORT_PINS = DEF_PORT_PINS,
  parameter int unsigned LIMIT_W   = DEF_LIMIT_W,
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_PINS,
  localparam int unsigned PORT_AW  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned ADDR_W   = PORT_AW + 1,
  localparam int unsigned DATA_W   = 2 * PORT_PINS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NUM_PINS-1:0] pin_raw_i,
  input  logic                bus_wr_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic [NUM_PINS-1:0] pin_filt_o
);
  logic [NUM_PORTS-1:0][LIMIT_W-1:0]   port_limit;
  logic [NUM_PORTS-1:0][PORT_PINS-1:0] pin_en;

  dbnc_regs #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_PINS(PORT_PINS),
    .LIMIT_W  (LIMIT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .limit_o    (port_limit),
    .en_o       (pin_en)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dbnc_port #(
      .PORT_PINS(PORT_PINS),
      .LIMIT_W  (LIMIT_W)
    ) port_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .raw_i  (pin_raw_i[p*PORT_PINS +: PORT_PINS]),
      .en_i   (pin_en[p]),
      .limit_i(port_limit[p]),
      .filt_o (pin_filt_o[p*PORT_PINS +: PORT_PINS])
    );
  end
endmodule

// File: rtl/dbnc_bank_chk.sv
module dbnc_bank_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_PINS = 8,
  parameter int unsigned LIMIT_W   = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned NUM_PINS = NUM_PORTS * PORT_PINS,
  localparam int unsigned PORT_AW  = ADDR_W - 1
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              tick_i,
  input logic [NUM_PINS-1:0]               pin_raw_i,
  input logic [NUM_PINS-1:0]               pin_filt_o,
  input logic                              bus_wr_i,
  input logic [ADDR_W-1:0]                 bus_addr_i,
  input logic [DATA_W-1:0]                 bus_wdata_i,
  input logic [NUM_PINS-1:0]               pin_en_i,
  input logic [NUM_PORTS-1:0][LIMIT_W-1:0] port_limit_i
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    localparam int unsigned P = g / PORT_PINS;
    logic live;
    assign live = pin_en_i[g] && (port_limit_i[P] != '0);

    // R4
    bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pin_en_i[g] |-> (pin_filt_o[g] == pin_raw_i[g]));

    // R7
    zero_len_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pin_en_i[g] && port_limit_i[P] == '0) |-> (pin_filt_o[g] == pin_raw_i[g]));

    // R11
    tick_only_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && $past(live) && !$stable(pin_filt_o[g])) |-> $past(tick_i));

    // R5
    settle_to_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && $past(live) && !$stable(pin_filt_o[g])) |-> (pin_filt_o[g] == $past(pin_raw_i[g])));
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // R2
    limit_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == {1'b0, PORT_AW'(p)})
      |=> (port_limit_i[p] == $past(bus_wdata_i[LIMIT_W-1:0])));

    // R3
    masked_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == {1'b1, PORT_AW'(p)})
      |=> (pin_en_i[p*PORT_PINS +: PORT_PINS] ==
           (($past(pin_en_i[p*PORT_PINS +: PORT_PINS]) & ~$past(bus_wdata_i[2*PORT_PINS-1:PORT_PINS]))
           | ($past(bus_wdata_i[PORT_PINS-1:0]) & $past(bus_wdata_i[2*PORT_PINS-1:PORT_PINS])))));
  end
endmodule

bind dbnc_bank dbnc_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PORT_PINS(PORT_PINS),
  .LIMIT_W  (LIMIT_W),
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .pin_raw_i   (pin_raw_i),
  .pin_filt_o  (pin_filt_o),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pin_en_i    (pin_en),
  .port_limit_i(port_limit)
);

// File: tb/dbnc_bank_tb_top.sv
module dbnc_bank_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        tick_i;
  logic [31:0] pin_raw_i;
  logic        bus_wr_i;
  logic [2:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic [31:0] pin_filt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  dbnc_bank dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .pin_raw_i  (pin_raw_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .pin_filt_o (pin_filt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick_i = t;
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  function automatic logic [31:0] expv(input logic [31:0] o, input logic [31:0] n,
                                       input logic [3:0][7:0] l, input int k);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) r[p*8 +: 8] = (k >= int'(l[p])) ? n[p*8 +: 8] : o[p*8 +: 8];
    return r;
  endfunction

  // All pins enabled and settled at pin_raw_i on entry.
  task automatic sweep(input logic [3:0][7:0] l, input logic [31:0] nxt);
    logic [31:0] old;
    for (int p = 0; p < 4; p++) wr(3'(p), {8'h00, l[p]});
    old = pin_raw_i;
    pin_raw_i = nxt;
    #1 chk("R7 R8 start", pin_filt_o, expv(old, nxt, l, 0));
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b0);
      chk("R11 idle", pin_filt_o, expv(old, nxt, l, k - 1));
      cyc(1'b1);
      chk("R5 R8 tick", pin_filt_o, expv(old, nxt, l, k));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_ni = 1'b0; tick_i = 1'b0; bus_wr_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
    pin_raw_i = 32'h1357_9BDF;
    #2 chk("R1 filt in reset", pin_filt_o, 32'h1357_9BDF);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    for (int p = 0; p < 4; p++) begin
      rd(3'(p), d);     chk("R1 length", {16'h0, d}, 32'h0);
      rd(3'(4 + p), d); chk("R1 enable", {16'h0, d}, 32'h0);
    end

    // R4 bypass with all enables clear
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      pin_raw_i = 32'hA5C3_0F96 ^ (32'h1111_1111 * i);
      #1 chk("R4 bypass", pin_filt_o, pin_raw_i);
    end
    cyc(1'b1);
    chk("R4 bypass tick", pin_filt_o, pin_raw_i);

    // R2 length registers
    wr(3'd0, 16'h002A);
    rd(3'd0, d); chk("R2 port0", {16'h0, d}, 32'h2A);
    rd(3'd1, d); chk("R2 port1 untouched", {16'h0, d}, 32'h0);
    wr(3'd1, 16'hFF07);
    rd(3'd1, d); chk("R2 upper ignored", {16'h0, d}, 32'h07);
    rd(3'd0, d); chk("R2 port0 kept", {16'h0, d}, 32'h2A);

    // R3 masked enable alias on port 2
    wr(3'd6, 16'hFFA5);
    rd(3'd6, d); chk("R3 full write", {16'h0, d}, 32'hA5);
    wr(3'd6, 16'h0F00);
    rd(3'd6, d); chk("R3 low nibble cleared", {16'h0, d}, 32'hA0);
    wr(3'd6, 16'h00FF);
    rd(3'd6, d); chk("R3 no strobe", {16'h0, d}, 32'hA0);
    wr(3'd6, 16'h0101);
    rd(3'd6, d); chk("R3 one bit", {16'h0, d}, 32'hA1);
    rd(3'd5, d); chk("R3 other port", {16'h0, d}, 32'h0);

    // R10 enable all with steady input
    pin_raw_i = 32'h0000_0000;
    cyc(1'b0);
    for (int p = 0; p < 4; p++) wr(3'(4 + p), 16'hFFFF);
    chk("R10 enable steady", pin_filt_o, 32'h0);

    // R5 R8 R11 sweeps over lengths and patterns
    sweep({8'd4, 8'd3, 8'd2, 8'd1}, 32'hFFFF_FFFF);
    sweep({8'd1, 8'd2, 8'd3, 8'd4}, 32'hA5A5_5A5A);
    sweep({8'd1, 8'd4, 8'd0, 8'd2}, 32'h0F0F_1234);
    sweep({8'd3, 8'd3, 8'd3, 8'd3}, 32'h0000_0000);

    // R6 restart on return to settled level
    wr(3'd0, 16'h0003);
    pin_raw_i[0] = 1'b1;
    cyc(1'b1); cyc(1'b1);
    chk("R6 before revert", {31'h0, pin_filt_o[0]}, 32'h0);
    pin_raw_i[0] = 1'b0;
    cyc(1'b0);
    pin_raw_i[0] = 1'b1;
    cyc(1'b1); cyc(1'b1);
    chk("R6 restarted", {31'h0, pin_filt_o[0]}, 32'h0);
    cyc(1'b1);
    chk("R6 settles", {31'h0, pin_filt_o[0]}, 32'h1);

    // R9 independent counters on one port
    pin_raw_i[1] = 1'b1;
    cyc(1'b1);
    pin_raw_i[2] = 1'b1;
    cyc(1'b1); cyc(1'b1);
    chk("R9 first pin", {30'h0, pin_filt_o[2:1]}, 32'h1);
    cyc(1'b1);
    chk("R9 second pin", {30'h0, pin_filt_o[2:1]}, 32'h3);

    // R4 disable mid-count, R10 re-enable
    pin_raw_i[4] = 1'b1;
    cyc(1'b1);
    chk("R5 mid-count", {31'h0, pin_filt_o[4]}, 32'h0);
    wr(3'd4, 16'h1000);
    chk("R4 disabled mid-count", {31'h0, pin_filt_o[4]}, 32'h1);
    wr(3'd4, 16'h1010);
    chk("R10 re-enable", {31'h0, pin_filt_o[4]}, 32'h1);
    cyc(1'b1); cyc(1'b1); cyc(1'b1);
    chk("R10 stays", {31'h0, pin_filt_o[4]}, 32'h1);

    // R7 zero length on port 1
    wr(3'd1, 16'h0000);
    pin_raw_i[8] = 1'b1;
    #1 chk("R7 rise", {31'h0, pin_filt_o[8]}, 32'h1);
    @(negedge clk_i);
    pin_raw_i[8] = 1'b0;
    #1 chk("R7 fall", {31'h0, pin_filt_o[8]}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule